// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block turns a small set of external interrupt pins into interrupt requests for a processor core. Each pin first passes through a two-flop synchronizer. A per-channel event detector then watches the synchronized samples. A two-bit mode field picks what counts as an event: a falling edge, a rising edge, either edge, or bypass. In bypass mode, a trigger-type select picks between a falling edge and a low level held for a minimum number of cycles.

Each channel has two independent flags. The detection flag records edges, and only software clears it. The request flag is what the core polls, and it is cleared by the core's acknowledge when it vectors to the handler. Both flag vectors can be written through a simple write port. A hardware set in the same cycle as a write or an acknowledge always wins, so no event is lost. Edges come only from the pin samples, never from the flag state, so clearing a flag while a pin is still low cannot create a false event.

Top module: `exti_edge_detector`

## Requirements
- R1: While reset is high and in the cycle after it, every detection flag and every request flag reads 0. The synchronizer and history registers start at the idle-high level.
- R2: Mode 2'b00 (falling edge): a high-to-low pin change sets both flags of the channel. The flags appear after the third rising clock edge after the change (two synchronizer stages plus the flag register). A low-to-high change sets nothing.
- R3: Mode 2'b01 (rising edge): a low-to-high pin change sets both flags with the same latency as R2. A high-to-low change sets nothing.
- R4: Mode 2'b10 (both edges): either pin transition sets both flags.
- R5: Mode 2'b11 (bypass) with the trigger select at 0: a falling edge sets both flags. A rising edge sets nothing.
- R6: Mode 2'b11 with the trigger select at 1: the request flag is set in every cycle once the synchronized pin has been low for MIN_LOW consecutive samples (default 2). The detection flag is never set. A low pulse seen for a single sample sets nothing.
- R7: An acknowledge bit clears that channel's request flag and leaves its detection flag unchanged.
- R8: A write to the detection register loads the written vector into the detection flags (a 1 sets, a 0 clears) and does not change any request flag. A write to the request register does not change any detection flag.
- R9: Clearing the detection flag while the pin is held low does not set it again. The flag stays 0 until a new qualifying pin transition occurs.
- R10: When a hardware set coincides with a software write of 0 or an acknowledge on the same channel, the flag ends up set.
- R11: In every mode, the trigger select has no effect outside mode 2'b11.
- R12: Channels are independent. Events, acknowledges and modes on one channel never change another channel's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_CH | Asynchronous external interrupt pins |
| mode_i | input | 2*N_CH | Per-channel mode, channel c in bits [2c+1:2c] |
| lvl_sel_i | input | N_CH | Bypass trigger type: 0 falling edge, 1 low level |
| wr_det_en_i | input | 1 | Write strobe for the detection flag vector |
| wr_det_data_i | input | N_CH | Data for the detection flag write |
| wr_req_en_i | input | 1 | Write strobe for the request flag vector |
| wr_req_data_i | input | N_CH | Data for the request flag write |
| ack_i | input | N_CH | Per-channel vectoring acknowledge, clears request flag |
| det_o | output | N_CH | Detection flags |
| irq_o | output | N_CH | Request flags polled by the core |

## Verification
The assertions assume that the mode and trigger-select inputs stay fixed while an event is in flight through the synchronizer. They also assume the pins are held high during reset, so the idle-high history never sees a false edge. The stimulus changes mode fields only after every pin has returned high and the flags have been cleared. It drives pins only on the falling clock edge. It holds each pin level for at least four cycles, except in the deliberate short-pulse case for the low-level trigger.

// File: rtl/exti_pkg.sv
package exti_pkg;
  typedef enum logic [1:0] {
    EXM_FALL   = 2'b00,
    EXM_RISE   = 2'b01,
    EXM_BOTH   = 2'b10,
    EXM_BYPASS = 2'b11
  } exti_mode_e;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int N_CH   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] pin_i,
  output logic [N_CH-1:0] sync_o
);
  logic [STAGES-1:0][N_CH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/exti_edge.sv
module exti_edge
  import exti_pkg::*;
#(
  parameter int MIN_LOW = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_i,
  input  logic [1:0] mode_i,
  input  logic       lvl_sel_i,
  output logic       det_set_o,
  output logic       req_set_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_LOW);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW - 1);

  logic          prev_q;
  logic [CW-1:0] low_cnt;
  logic          fall, rise, low_held;
  exti_mode_e    mode;

  assign mode = exti_mode_e'(mode_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      prev_q <= smp_i;
      if (smp_i)              low_cnt <= '0;
      else if (low_cnt < SAT) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign fall     = prev_q & ~smp_i;
  assign rise     = ~prev_q & smp_i;
  assign low_held = ~smp_i & (low_cnt >= LIM);

  always_comb begin
    det_set_o = 1'b0;
    req_set_o = 1'b0;
    unique case (mode)
      EXM_FALL: begin det_set_o = fall;        req_set_o = fall;        end
      EXM_RISE: begin det_set_o = rise;        req_set_o = rise;        end
      EXM_BOTH: begin det_set_o = fall | rise; req_set_o = fall | rise; end
      EXM_BYPASS: begin
        if (lvl_sel_i) begin
          det_set_o = 1'b0;
          req_set_o = low_held;
        end else begin
          det_set_o = fall;
          req_set_o = fall;
        end
      end
      default: ;
    endcase
  end

  // R6: level trigger never marks the detection flag
  p_level_no_det_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == EXM_BYPASS && lvl_sel_i) |-> !det_set_o);
  // R9: a detection set requires a change between successive samples
  p_det_on_change_r9: assert property (@(posedge clk) disable iff (rst)
    det_set_o |-> (prev_q != smp_i));
  // R6: level request only after the sample has been low last cycle too
  p_level_needs_run_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == EXM_BYPASS && lvl_sel_i && req_set_o) |-> (!smp_i && !prev_q));
  // R2: detection set always accompanied by request set
  p_det_with_req_r2: assert property (@(posedge clk) disable iff (rst)
    det_set_o |-> req_set_o);
endmodule

// File: rtl/exti_flags.sv
module exti_flags #(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] det_set_i,
  input  logic [N_CH-1:0] req_set_i,
  input  logic            wr_det_en_i,
  input  logic [N_CH-1:0] wr_det_data_i,
  input  logic            wr_req_en_i,
  input  logic [N_CH-1:0] wr_req_data_i,
  input  logic [N_CH-1:0] ack_i,
  output logic [N_CH-1:0] det_o,
  output logic [N_CH-1:0] req_o
);
  logic [N_CH-1:0] det_q, req_q, det_d, req_d;

  always_comb begin
    det_d = det_set_i | (wr_det_en_i ? wr_det_data_i : det_q);
    req_d = req_set_i | (wr_req_en_i ? wr_req_data_i : (req_q & ~ack_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q <= '0;
      req_q <= '0;
    end else begin
      det_q <= det_d;
      req_q <= req_d;
    end
  end

  assign det_o = det_q;
  assign req_o = req_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    // R10: hardware set survives any same-cycle clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
      (det_set_i[c] && req_set_i[c]) |=> (det_o[c] && req_o[c]));
    // R7: acknowledge without a new set drops the request
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
      (ack_i[c] && !req_set_i[c] && !wr_req_en_i) |=> !req_o[c]);
    // R7/R8: detection flag moves only on a set or a detection write
    p_det_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!det_set_i[c] && !wr_det_en_i) |=> (det_o[c] == $past(det_o[c])));
  end
endmodule

// File: rtl/exti_edge_detector.sv
module exti_edge_detector #(
  parameter int N_CH    = 2,
  parameter int MIN_LOW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   pin_i,
  input  logic [2*N_CH-1:0] mode_i,
  input  logic [N_CH-1:0]   lvl_sel_i,
  input  logic              wr_det_en_i,
  input  logic [N_CH-1:0]   wr_det_data_i,
  input  logic              wr_req_en_i,
  input  logic [N_CH-1:0]   wr_req_data_i,
  input  logic [N_CH-1:0]   ack_i,
  output logic [N_CH-1:0]   det_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [N_CH-1:0] smp, det_set, req_set;

  exti_sync #(.N_CH(N_CH), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .sync_o(smp)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    exti_edge #(.MIN_LOW(MIN_LOW)) u_edge (
      .clk(clk), .rst(rst), .smp_i(smp[c]),
      .mode_i(mode_i[2*c +: 2]), .lvl_sel_i(lvl_sel_i[c]),
      .det_set_o(det_set[c]), .req_set_o(req_set[c])
    );
  end

  exti_flags #(.N_CH(N_CH)) u_flags (
    .clk(clk), .rst(rst),
    .det_set_i(det_set), .req_set_i(req_set),
    .wr_det_en_i(wr_det_en_i), .wr_det_data_i(wr_det_data_i),
    .wr_req_en_i(wr_req_en_i), .wr_req_data_i(wr_req_data_i),
    .ack_i(ack_i), .det_o(det_o), .req_o(irq_o)
  );

  // R1: flags are empty right after a reset cycle
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (det_o == '0 && irq_o == '0));
endmodule

// File: tb/exti_edge_detector_test.sv
module exti_edge_detector_test;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0]   pin, lvl, wdd, wrd, ack;
  logic [2*N-1:0] mode;
  logic           wde, wre;
  logic [N-1:0]   det, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  exti_edge_detector #(.N_CH(N), .MIN_LOW(2)) uut (
    .clk(clk), .rst(rst), .pin_i(pin), .mode_i(mode), .lvl_sel_i(lvl),
    .wr_det_en_i(wde), .wr_det_data_i(wdd),
    .wr_req_en_i(wre), .wr_req_data_i(wrd),
    .ack_i(ack), .det_o(det), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    wde = 1'b1; wdd = '0; wre = 1'b1; wrd = '0;
    tick(1);
    wde = 1'b0; wre = 1'b0;
  endtask

  function automatic string tag(input int m, input int l);
    if (m == 0) return "R2";
    if (m == 1) return "R3";
    if (m == 2) return "R4";
    if (l == 0) return "R5";
    return "R6";
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pin = '1; lvl = '0; mode = '0; ack = '0;
    wde = 1'b0; wdd = '0; wre = 1'b0; wrd = '0;
    tick(3);
    chk("R1 det in reset", det, '0);
    chk("R1 irq in reset", irq, '0);
    rst = 1'b0;
    tick(1);
    chk("R1 det after reset", det, '0);
    chk("R1 irq after reset", irq, '0);

    // sweep every channel, mode and trigger select (R11: select only matters in bypass)
    for (int ch = 0; ch < N; ch++) begin
      for (int m = 0; m < 4; m++) begin
        for (int l = 0; l < 2; l++) begin
          logic [N-1:0] one;
          bit lv, fe, re;
          string t;
          one = N'(1) << ch;
          lv  = (m == 3 && l == 1);
          fe  = (m == 0 || m == 2 || (m == 3 && l == 0));
          re  = (m == 1 || m == 2);
          t   = tag(m, l);
          mode = '0; mode[2*ch +: 2] = 2'(m);
          lvl  = '0; lvl[ch] = l[0];
          clear_all();
          pin[ch] = 1'b0;
          tick(2);
          chk({t, " fall latency det"}, det, '0);
          chk({t, " fall latency irq"}, irq, '0);
          tick(1);
          chk({t, " fall det"}, det, fe ? one : '0);
          chk({t, " fall irq"}, irq, fe ? one : '0);
          tick(1);
          chk({t, " R12 fall det"}, det, fe ? one : '0);
          chk({t, " R12 fall irq"}, irq, (fe || lv) ? one : '0);
          clear_all();
          tick(3);
          chk({t, " R9 det after clear low"}, det, '0);
          chk({t, " R9 irq after clear low"}, irq, lv ? one : '0);
          pin[ch] = 1'b1;
          tick(4);
          chk({t, " rise det"}, det, re ? one : '0);
          chk({t, " rise irq"}, irq, (re || lv) ? one : '0);
          clear_all();
          chk({t, " cleared"}, det | irq, '0);
        end
      end
    end

    // R6: short low pulse ignored, two-sample low accepted
    mode = {2'b00, 2'b11}; lvl = 2'b01;
    clear_all();
    pin[0] = 1'b0; tick(1); pin[0] = 1'b1; tick(6);
    chk("R6 short pulse irq", irq, '0);
    pin[0] = 1'b0; tick(2); pin[0] = 1'b1; tick(6);
    chk("R6 two-sample low irq", irq, 2'b01);
    chk("R6 two-sample low det", det, '0);
    clear_all();

    // R7: acknowledge clears request only
    mode = '0; lvl = '0;
    pin[0] = 1'b0; tick(3);
    ack = 2'b01; tick(1); ack = '0;
    chk("R7 irq after ack", irq, '0);
    chk("R7 det after ack", det, 2'b01);
    pin[0] = 1'b1; tick(4); clear_all();

    // R8: register writes
    pin[1] = 1'b0; tick(3);
    wde = 1'b1; wdd = '0; tick(1); wde = 1'b0;
    chk("R8 det write clears", det, '0);
    chk("R8 irq untouched by det write", irq, 2'b10);
    wde = 1'b1; wdd = 2'b10; tick(1); wde = 1'b0;
    chk("R8 det write sets", det, 2'b10);
    wre = 1'b1; wrd = '0; tick(1); wre = 1'b0;
    chk("R8 irq write clears", irq, '0);
    chk("R8 det untouched by irq write", det, 2'b10);
    pin[1] = 1'b1; tick(4); clear_all();

    // R10: set beats same-cycle clear and acknowledge
    pin[0] = 1'b0; tick(2);
    wde = 1'b1; wdd = '0; wre = 1'b1; wrd = '0; ack = 2'b01;
    tick(1);
    wde = 1'b0; wre = 1'b0; ack = '0;
    chk("R10 det kept", det, 2'b01);
    chk("R10 irq kept", irq, 2'b01);
    pin[0] = 1'b1; tick(4); clear_all();

    // R12: both channels at once, acknowledge one
    mode = {2'b10, 2'b10};
    pin = '0; tick(3);
    ack = 2'b10; tick(1); ack = '0;
    chk("R12 irq per channel", irq, 2'b01);
    chk("R12 det per channel", det, 2'b11);
    pin = '1; tick(4); clear_all();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule